// File: doc/BRIEF.md
# Snoop-Side Coherence Responder

This block serves as the bus-facing half of a write-invalidate, direct-mapped cache controller. It watches every command that appears on the shared bus. Each command carries a source ID and an address. When a command arrives from another agent, the block looks up the indexed line in the cache's tag, state and data arrays. Those arrays sit outside the block and are shared with the processor side. The block then decides whether the line must change its two-bit coherence state. If this cache holds the only valid copy, the block also pushes the line's data onto the bus.

The block is driven by a three-state machine with states `S_IDLE`, `S_LOOKUP` and `S_FLUSH`.

- **`S_IDLE` to `S_LOOKUP` (take):** a command is taken only in `S_IDLE`, and only if it is a read miss or a write miss from a foreign source.
- **`S_LOOKUP` to `S_IDLE` (done):** in `S_LOOKUP` the block presents the index, reads the line and issues at most one state write. With no exclusive hit, it returns straight to `S_IDLE`.
- **`S_LOOKUP` to `S_FLUSH` (flush):** a hit on an exclusive line moves the block to `S_FLUSH`.
- **`S_FLUSH` to `S_IDLE` (release):** in `S_FLUSH` the captured data is driven for one bus data phase, then the block returns to `S_IDLE`.

The bus is expected to space snoop commands at least three cycles apart. A command that arrives outside `S_IDLE` is not taken.

A snoop state write always wins over a processor-side update. If the processor asks to update the same line index in the same cycle, it is told to stall.

Top module: `snoop_responder`

## Requirements
- R1: After reset, `st_wr_en`, `cpu_stall`, `drv_valid` and `mem_abort` are 0, and `drv_data` is 0.
- R2: A snoop is taken when `snp_valid` is 1 in an idle cycle. The address is split as `{tag, index}`, with the index in the low bits. If the indexed line's state is invalid (code 0), or its tag differs from the address tag, the snoop causes no state write and no data drive.
- R3: A read miss (command code 1) that hits a shared line (state code 1) causes no state write and no data drive.
- R4: A write miss (command code 2) that hits a shared line writes state invalid (code 0). It causes no data drive.
- R5: A read miss that hits an exclusive line (state code 2) writes state shared (code 1). The next cycle it drives the line data with `drv_valid`, and `mem_abort` is 1 in that cycle.
- R6: A write miss that hits an exclusive line writes state invalid (code 0). The next cycle it drives the line data with `drv_valid`, and `mem_abort` stays 0.
- R7: A command whose `snp_src` equals the block's own ID parameter has no effect on state, data or abort.
- R8: A write-back command (code 3) has no effect on state, data or abort.
- R9: The state write happens one cycle after the command cycle, in the lookup cycle. In that cycle `cpu_stall` is 1 exactly when `cpu_upd_en` is 1 and `cpu_upd_idx` equals the written index. Otherwise `cpu_stall` is 0.
- R10: `drv_valid` is high for exactly one cycle per flush. Outside that cycle `drv_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snp_valid | input | 1 | Bus command present |
| snp_cmd | input | 2 | Command: 0 none, 1 read miss, 2 write miss, 3 write-back |
| snp_src | input | ID_W | Source ID of the requesting agent |
| snp_addr | input | TAG_W+IDX_W | Bus address `{tag, index}` |
| arr_rd_idx | output | IDX_W | Line index presented to the arrays |
| arr_rd_tag | input | TAG_W | Tag of the indexed line |
| arr_rd_state | input | 2 | Coherence state of the indexed line |
| arr_rd_data | input | DATA_W | Data of the indexed line |
| st_wr_en | output | 1 | Snoop state write strobe |
| st_wr_idx | output | IDX_W | Index of the state write |
| st_wr_state | output | 2 | New state value |
| cpu_upd_en | input | 1 | Processor side wants to update a line |
| cpu_upd_idx | input | IDX_W | Index of the processor update |
| cpu_stall | output | 1 | Processor update must be held off this cycle |
| drv_valid | output | 1 | Data phase strobe |
| drv_data | output | DATA_W | Line data driven onto the bus |
| mem_abort | output | 1 | Memory must drop its own read |

## Verification
The bench sweeps every line state against every command code. Each pair is run with the tag matching and not matching, from a foreign source and from the own source, and with a processor update on the same index and on a different index.

It targets the corner cases that a wrong decode would break:
- A design that snooped its own requests would invalidate its own lines.
- A design that treated the write-back command as a miss would demote lines.
- A design that raised abort on a write-miss flush would starve memory of the read it needs.
- A stall on a non-conflicting index, or a strobe held for two cycles, shows up in the stall and strobe checks.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RDM  = 2'd1,
        BC_WRM  = 2'd2,
        BC_WBK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_FLUSH  = 2'd2
    } snp_fsm_e;

endpackage

// File: rtl/snp_accept.sv
module snp_accept #(
    parameter int ID_W  = 2,
    parameter int MY_ID = 1
) (
    input  logic            valid,
    input  logic [1:0]      cmd,
    input  logic [ID_W-1:0] src,
    output logic            take
);
    import snp_pkg::*;

    logic foreign;
    logic is_miss;

    // R7: a request issued by this cache is never snooped
    assign foreign = (src != ID_W'(MY_ID));
    // R8: only the two miss commands are acted on
    assign is_miss = (cmd == BC_RDM) || (cmd == BC_WRM);
    assign take    = valid && foreign && is_miss;

endmodule

// File: rtl/snp_react.sv
module snp_react #(
    parameter int TAG_W = 6
) (
    input  logic [1:0]       cmd,
    input  logic [1:0]       line_state,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             upd,
    output logic [1:0]       new_state,
    output logic             flush,
    output logic             abort
);
    import snp_pkg::*;

    logic hit;

    // R2: an invalid or foreign-tag line never reacts
    assign hit = (line_state != LN_INV) && (line_tag == req_tag);

    always_comb begin
        upd       = 1'b0;
        new_state = LN_INV;
        flush     = 1'b0;
        abort     = 1'b0;
        if (hit) begin
            unique case (line_state)
                LN_SHR: begin
                    // R3 stays shared on read, R4 drops on write
                    upd       = (cmd == BC_WRM);
                    new_state = LN_INV;
                end
                LN_EXC: begin
                    // R5 / R6: owner must supply data
                    upd       = 1'b1;
                    flush     = 1'b1;
                    new_state = (cmd == BC_RDM) ? LN_SHR : LN_INV;
                    abort     = (cmd == BC_RDM);
                end
                default: begin
                    upd = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder #(
    parameter int TAG_W  = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 1,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ID_W-1:0]   snp_src,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  arr_rd_idx,
    input  logic [TAG_W-1:0]  arr_rd_tag,
    input  logic [1:0]        arr_rd_state,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic              st_wr_en,
    output logic [IDX_W-1:0]  st_wr_idx,
    output logic [1:0]        st_wr_state,
    input  logic              cpu_upd_en,
    input  logic [IDX_W-1:0]  cpu_upd_idx,
    output logic              cpu_stall,
    output logic              drv_valid,
    output logic [DATA_W-1:0] drv_data,
    output logic              mem_abort
);
    import snp_pkg::*;

    snp_fsm_e          fsm_q, fsm_d;
    logic [1:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              abort_q;

    logic              take;
    logic              rx_upd, rx_flush, rx_abort;
    logic [1:0]        rx_state;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;

    assign idx_q = addr_q[IDX_W-1:0];
    assign tag_q = addr_q[ADDR_W-1:IDX_W];

    snp_accept #(.ID_W(ID_W), .MY_ID(MY_ID)) u_accept (
        .valid (snp_valid),
        .cmd   (snp_cmd),
        .src   (snp_src),
        .take  (take)
    );

    snp_react #(.TAG_W(TAG_W)) u_react (
        .cmd        (cmd_q),
        .line_state (arr_rd_state),
        .line_tag   (arr_rd_tag),
        .req_tag    (tag_q),
        .upd        (rx_upd),
        .new_state  (rx_state),
        .flush      (rx_flush),
        .abort      (rx_abort)
    );

    // next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            S_IDLE:   if (take) fsm_d = S_LOOKUP;
            S_LOOKUP: fsm_d = rx_flush ? S_FLUSH : S_IDLE;
            S_FLUSH:  fsm_d = S_IDLE;
            default:  fsm_d = S_IDLE;
        endcase
    end

    // state register and captured request/data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q   <= S_IDLE;
            cmd_q   <= BC_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            abort_q <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
            if (fsm_q == S_IDLE && take) begin
                cmd_q  <= snp_cmd;
                addr_q <= snp_addr;
            end
            if (fsm_q == S_LOOKUP) begin
                data_q  <= arr_rd_data;
                abort_q <= rx_abort;
            end
        end
    end

    // outputs
    always_comb begin
        arr_rd_idx  = idx_q;
        st_wr_idx   = idx_q;
        st_wr_en    = (fsm_q == S_LOOKUP) && rx_upd;
        st_wr_state = rx_state;
        cpu_stall   = st_wr_en && cpu_upd_en && (cpu_upd_idx == idx_q);
        drv_valid   = (fsm_q == S_FLUSH);
        drv_data    = (fsm_q == S_FLUSH) ? data_q : '0;
        mem_abort   = (fsm_q == S_FLUSH) && abort_q;
    end

endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk #(
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_wr_en,
    input logic [IDX_W-1:0]  st_wr_idx,
    input logic [1:0]        st_wr_state,
    input logic              cpu_upd_en,
    input logic [IDX_W-1:0]  cpu_upd_idx,
    input logic              cpu_stall,
    input logic              drv_valid,
    input logic [DATA_W-1:0] drv_data,
    input logic              mem_abort
);

    // R10: data phase lasts one cycle
    a_r10_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid |=> !drv_valid);

    // R10: data bus quiet outside the phase
    a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_valid |-> drv_data == '0);

    // R5: abort only alongside a data phase
    a_r5_abort_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort |-> drv_valid);

    // R5 / R6: a flush always follows its state write
    a_r6_flush_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_valid) |-> $past(st_wr_en));

    // R4: a snoop never grants ownership
    a_r4_no_promote: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |-> st_wr_state != 2'd2);

    // R9: stall only on a real index conflict
    a_r9_stall_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (st_wr_en && cpu_upd_en && cpu_upd_idx == st_wr_idx));

    // R9: one state write per snoop
    a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |=> !st_wr_en);

endmodule

bind snoop_responder snoop_responder_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_wr_en    (st_wr_en),
    .st_wr_idx   (st_wr_idx),
    .st_wr_state (st_wr_state),
    .cpu_upd_en  (cpu_upd_en),
    .cpu_upd_idx (cpu_upd_idx),
    .cpu_stall   (cpu_stall),
    .drv_valid   (drv_valid),
    .drv_data    (drv_data),
    .mem_abort   (mem_abort)
);

// File: tb/snoop_responder_bench.sv
module snoop_responder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W  = 6;
    localparam int IDX_W  = 2;
    localparam int DATA_W = 16;
    localparam int ID_W   = 2;
    localparam int MY_ID  = 1;
    localparam int ADDR_W = TAG_W + IDX_W;
    localparam int LINES  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_cmd = 2'd0;
    logic [ID_W-1:0]   snp_src = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic [IDX_W-1:0]  arr_rd_idx;
    logic [TAG_W-1:0]  arr_rd_tag;
    logic [1:0]        arr_rd_state;
    logic [DATA_W-1:0] arr_rd_data;
    logic              st_wr_en;
    logic [IDX_W-1:0]  st_wr_idx;
    logic [1:0]        st_wr_state;
    logic              cpu_upd_en = 1'b0;
    logic [IDX_W-1:0]  cpu_upd_idx = '0;
    logic              cpu_stall;
    logic              drv_valid;
    logic [DATA_W-1:0] drv_data;
    logic              mem_abort;

    logic [TAG_W-1:0]  tag_mem [LINES];
    logic [1:0]        st_mem  [LINES];
    logic [DATA_W-1:0] dat_mem [LINES];
    logic              pl_en = 1'b0;
    logic [IDX_W-1:0]  pl_idx = '0;
    logic [TAG_W-1:0]  pl_tag = '0;
    logic [1:0]        pl_st = '0;
    logic [DATA_W-1:0] pl_dat = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_responder #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
                      .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop_responder (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_src(snp_src), .snp_addr(snp_addr),
        .arr_rd_idx(arr_rd_idx), .arr_rd_tag(arr_rd_tag),
        .arr_rd_state(arr_rd_state), .arr_rd_data(arr_rd_data),
        .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_state(st_wr_state),
        .cpu_upd_en(cpu_upd_en), .cpu_upd_idx(cpu_upd_idx), .cpu_stall(cpu_stall),
        .drv_valid(drv_valid), .drv_data(drv_data), .mem_abort(mem_abort)
    );

    // cache array model
    assign arr_rd_tag   = tag_mem[arr_rd_idx];
    assign arr_rd_state = st_mem[arr_rd_idx];
    assign arr_rd_data  = dat_mem[arr_rd_idx];

    always @(posedge clk) begin
        if (pl_en) begin
            tag_mem[pl_idx] <= pl_tag;
            st_mem[pl_idx]  <= pl_st;
            dat_mem[pl_idx] <= pl_dat;
        end else if (st_wr_en) begin
            st_mem[st_wr_idx] <= st_wr_state;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preload(input int idx, input int tag, input int st, input int dat);
        @(negedge clk);
        pl_en  = 1'b1;
        pl_idx = IDX_W'(idx);
        pl_tag = TAG_W'(tag);
        pl_st  = 2'(st);
        pl_dat = DATA_W'(dat);
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic scenario(input int st, input int cmd, input bit hit,
                            input bit own, input bit same, input int n);
        int idx, tag, dat, btag;
        bit eff, e_wr, e_drv, e_abort;
        int e_new, e_final;
        string rq;
        idx  = n % LINES;
        tag  = (n * 5 + 3) % (1 << TAG_W);
        btag = hit ? tag : (tag ^ 6'h21);
        dat  = (n * 16'h0123 + 16'h0A5A) & 16'hFFFF;
        eff     = !own && hit && st != 0 && (cmd == 1 || cmd == 2);
        e_wr    = eff && (st == 2 || cmd == 2);
        e_new   = (cmd == 1) ? 1 : 0;
        e_drv   = eff && st == 2;
        e_abort = e_drv && cmd == 1;
        e_final = e_wr ? e_new : st;
        if (own)             rq = "R7";
        else if (cmd == 3)   rq = "R8";
        else if (!hit || st == 0) rq = "R2";
        else if (st == 1)    rq = (cmd == 1) ? "R3" : "R4";
        else                 rq = (cmd == 1) ? "R5" : "R6";

        preload(idx, tag, st, dat);
        // command cycle
        snp_valid = 1'b1;
        snp_cmd   = 2'(cmd);
        snp_src   = own ? ID_W'(MY_ID) : ID_W'(MY_ID + 1);
        snp_addr  = {TAG_W'(btag), IDX_W'(idx)};
        @(negedge clk);
        // lookup cycle
        snp_valid   = 1'b0;
        snp_cmd     = 2'd0;
        cpu_upd_en  = 1'b1;
        cpu_upd_idx = same ? IDX_W'(idx) : IDX_W'(idx + 1);
        #1;
        chk({rq, " state write"}, st_wr_en, e_wr);
        if (e_wr) chk({rq, " new state"}, st_wr_state, e_new);
        chk("R9 cpu stall", cpu_stall, e_wr && same);
        @(negedge clk);
        cpu_upd_en = 1'b0;
        // data phase cycle
        chk({rq, " drv_valid"}, drv_valid, e_drv);
        chk({rq, " drv_data"}, drv_data, e_drv ? dat : 0);
        chk({rq, " mem_abort"}, mem_abort, e_abort);
        @(negedge clk);
        chk("R10 strobe dropped", drv_valid, 0);
        chk({rq, " final state"}, st_mem[idx], e_final);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int n;
        for (int i = 0; i < LINES; i++) begin
            tag_mem[i] = '0;
            st_mem[i]  = '0;
            dat_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 st_wr_en", st_wr_en, 0);
        chk("R1 cpu_stall", cpu_stall, 0);
        chk("R1 drv_valid", drv_valid, 0);
        chk("R1 mem_abort", mem_abort, 0);
        chk("R1 drv_data", drv_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        n = 0;
        for (int st = 0; st < 3; st++)
            for (int cmd = 1; cmd < 4; cmd++)
                for (int hit = 0; hit < 2; hit++)
                    for (int own = 0; own < 2; own++)
                        for (int same = 0; same < 2; same++) begin
                            scenario(st, cmd, hit[0], own[0], same[0], n);
                            n++;
                        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule